// File: doc/BRIEF.md
# Flow tuple hash unit

This block reduces the addressing tuple of a packet flow to a bucket index for a flow-offload lookup table. Each request carries a packet-kind code and two candidate tuples. The IPv4 tuple has three 32-bit words: the combined ports word, the destination address and the source address. The IPv6 tuple has four source address words, four destination address words and a ports word. The packet kind decides which tuple is used and how it is reduced to three 32-bit operands. Those operands then go through a fixed mix. The mix is a bitwise select, a byte rotation, a three-way XOR and a half-word fold. The result is then masked to the table size.

Packet kinds that the hash does not cover are still accepted. These are the tunnel kinds and any unassigned code. They return the all-ones bucket value and raise a flag, so the consumer can discard the result.

Requests enter and leave on valid/ready streams. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register until the edge where `out_valid` and `out_ready` are both high. The input side is ready whenever that register is empty or is being drained in the same cycle. A stalled consumer therefore stops the producer without losing or altering a result.

Top module: `flow_tuple_hash`

## Requirements
- R1: The kind code is 3 bits wide. Code 0 is IPv4 NAPT and code 1 is IPv4 route. For both, the operands are A = ports word, B = destination address and C = source address, taken from the IPv4 inputs.
- R2: Code 3 is IPv6 3-tuple and code 4 is IPv6 5-tuple. For both, the operands are built from the IPv6 inputs, where word k of an address is bits [32k+31:32k]. A = src3^dst3^ports, B = src2^dst2^dst0 and C = src1^dst1^src0.
- R3: The index is computed in four steps. First h = (A&B)|(~A&C). Then h is rotated left by 8 bits. Then h is XORed with A^B^C. Finally h is XORed with h>>16 and ANDed with NUM_ENTRIES-1.
- R4: Code 2 (IPv4 tunnel), code 5 (IPv6 tunnel) and codes 6 and 7 give out_index = NUM_ENTRIES-1 with out_unsup = 1. Supported codes give out_unsup = 0.
- R5: A request accepted on one clock edge appears on the outputs after that edge, with out_valid high.
- R6: While out_valid is high and out_ready is low, out_valid stays high, out_index and out_unsup stay unchanged, and in_ready is low.
- R7: When a result is drained and no new request is accepted on the same edge, out_valid goes low. When a result is drained and a new request is accepted on the same edge, the new result replaces the old one with no gap.
- R8: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_kind | input | 3 | Packet kind code |
| v4_ports | input | 32 | IPv4 ports word |
| v4_dst | input | 32 | IPv4 destination address |
| v4_src | input | 32 | IPv4 source address |
| v6_src | input | 128 | IPv6 source address, word k at [32k+31:32k] |
| v6_dst | input | 128 | IPv6 destination address, same layout |
| v6_ports | input | 32 | IPv6 ports word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_index | output | IDX_W (14) | Bucket index |
| out_unsup | output | 1 | Kind not hashable |

## Verification
The hardest case to reach from the ports is a drain and a refill on the same edge while the consumer has been stalling. In that case in_ready must rise in the same cycle as out_ready, and the old result must be replaced without a bubble. The stimulus holds out_ready low with a second request waiting. It checks that the first result is frozen and that in_ready is low. It then raises out_ready and expects the second result on the very next cycle. Random tuples over all eight kind codes cover the operand folding. Directed cases also cover zero tuples and IPv6 addresses that cancel each other.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
  typedef enum logic [2:0] {
    KIND_V4_NAPT   = 3'd0,
    KIND_V4_ROUTE  = 3'd1,
    KIND_V4_TUNNEL = 3'd2,
    KIND_V6_3T     = 3'd3,
    KIND_V6_5T     = 3'd4,
    KIND_V6_TUNNEL = 3'd5,
    KIND_RSVD6     = 3'd6,
    KIND_RSVD7     = 3'd7
  } pkt_kind_e;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
  } hash_ops_t;

  localparam int WORD_W = 32;
  localparam int V6_WORDS = 4;
endpackage

// File: rtl/flow_hash_opsel.sv
module flow_hash_opsel
  import flow_hash_pkg::*;
(
  input  logic [2:0]                 kind,
  input  logic [WORD_W-1:0]          v4_ports,
  input  logic [WORD_W-1:0]          v4_dst,
  input  logic [WORD_W-1:0]          v4_src,
  input  logic [V6_WORDS*WORD_W-1:0] v6_src,
  input  logic [V6_WORDS*WORD_W-1:0] v6_dst,
  input  logic [WORD_W-1:0]          v6_ports,
  output hash_ops_t                  ops,
  output logic                       unsup
);
  logic [WORD_W-1:0] s [V6_WORDS];
  logic [WORD_W-1:0] d [V6_WORDS];

  for (genvar k = 0; k < V6_WORDS; k++) begin : g_split
    assign s[k] = v6_src[k*WORD_W +: WORD_W];
    assign d[k] = v6_dst[k*WORD_W +: WORD_W];
  end

  always_comb begin
    ops   = '0;
    unsup = 1'b0;
    case (pkt_kind_e'(kind))
      KIND_V4_NAPT, KIND_V4_ROUTE: begin
        ops.a = v4_ports;
        ops.b = v4_dst;
        ops.c = v4_src;
      end
      KIND_V6_3T, KIND_V6_5T: begin
        ops.a = s[3] ^ d[3] ^ v6_ports;
        ops.b = s[2] ^ d[2] ^ d[0];
        ops.c = s[1] ^ d[1] ^ s[0];
      end
      default: unsup = 1'b1;
    endcase
  end
endmodule

// File: rtl/flow_hash_mix.sv
module flow_hash_mix
  import flow_hash_pkg::*;
#(
  parameter int NUM_ENTRIES = 16384,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  hash_ops_t        ops,
  input  logic             unsup,
  output logic [IDX_W-1:0] idx
);
  localparam logic [WORD_W-1:0] MASK32 = WORD_W'(NUM_ENTRIES - 1);

  logic [WORD_W-1:0] sel, rot, mixed, folded;

  always_comb begin
    sel    = (ops.a & ops.b) | (~ops.a & ops.c);
    rot    = {sel[23:0], sel[31:24]};
    mixed  = rot ^ ops.a ^ ops.b ^ ops.c;
    folded = mixed ^ (mixed >> 16);
    if (unsup) idx = IDX_W'(MASK32);
    else       idx = IDX_W'(folded & MASK32);
  end
endmodule

// File: rtl/flow_hash_stage.sv
module flow_hash_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R5
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R7
endmodule

// File: rtl/flow_tuple_hash.sv
module flow_tuple_hash
  import flow_hash_pkg::*;
#(
  parameter int NUM_ENTRIES = 16384,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_kind,
  input  logic [31:0]      v4_ports,
  input  logic [31:0]      v4_dst,
  input  logic [31:0]      v4_src,
  input  logic [127:0]     v6_src,
  input  logic [127:0]     v6_dst,
  input  logic [31:0]      v6_ports,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_index,
  output logic             out_unsup
);
  hash_ops_t        ops;
  logic             unsup;
  logic [IDX_W-1:0] idx;

  flow_hash_opsel u_opsel (
    .kind(in_kind), .v4_ports(v4_ports), .v4_dst(v4_dst), .v4_src(v4_src),
    .v6_src(v6_src), .v6_dst(v6_dst), .v6_ports(v6_ports),
    .ops(ops), .unsup(unsup)
  );

  flow_hash_mix #(.NUM_ENTRIES(NUM_ENTRIES)) u_mix (
    .ops(ops), .unsup(unsup), .idx(idx)
  );

  flow_hash_stage #(.W(IDX_W + 1)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data({unsup, idx}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data({out_unsup, out_index})
  );

  AST_UNSUP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unsup |-> out_index == IDX_W'(NUM_ENTRIES - 1)); // R4
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
endmodule

// File: tb/flow_tuple_hash_test.sv
module flow_tuple_hash_test;
  localparam int N = 16384;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid, out_unsup;
  logic [2:0] in_kind = 0;
  logic [31:0] v4_ports = 0, v4_dst = 0, v4_src = 0, v6_ports = 0;
  logic [127:0] v6_src = 0, v6_dst = 0;
  logic [IW-1:0] out_index;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  flow_tuple_hash #(.NUM_ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .v4_ports(v4_ports), .v4_dst(v4_dst), .v4_src(v4_src),
    .v6_src(v6_src), .v6_dst(v6_dst), .v6_ports(v6_ports),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_index(out_index), .out_unsup(out_unsup)
  );

  function automatic logic [31:0] w(input logic [127:0] v, input int k);
    return v[k*32 +: 32];
  endfunction

  function automatic logic [IW:0] model(input logic [2:0] k);
    logic [31:0] a, b, c, h;
    if (k == 0 || k == 1) begin
      a = v4_ports; b = v4_dst; c = v4_src;
    end else if (k == 3 || k == 4) begin
      a = w(v6_src,3) ^ w(v6_dst,3) ^ v6_ports;
      b = w(v6_src,2) ^ w(v6_dst,2) ^ w(v6_dst,0);
      c = w(v6_src,1) ^ w(v6_dst,1) ^ w(v6_src,0);
    end else
      return {1'b1, IW'(N - 1)};
    h = (a & b) | (~a & c);
    h = (h << 8) | (h >> 24);
    h = h ^ a ^ b ^ c;
    h = h ^ (h >> 16);
    h = h & (N - 1);
    return {1'b0, h[IW-1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randomize_tuple();
    v4_ports = $urandom; v4_dst = $urandom; v4_src = $urandom; v6_ports = $urandom;
    v6_src = {$urandom, $urandom, $urandom, $urandom};
    v6_dst = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic send_check(input logic [2:0] k, input string req);
    logic [IW:0] e;
    @(negedge clk);
    in_kind = k; in_valid = 1; out_ready = 1;
    e = model(k);
    @(negedge clk);
    in_valid = 0;
    check(out_valid === 1'b1, "R5", 32'(out_valid), 1);
    check(out_index === e[IW-1:0], req, 32'(out_index), 32'(e[IW-1:0]));
    check(out_unsup === e[IW], "R4", 32'(out_unsup), 32'(e[IW]));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [IW:0] e1, e2;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8", 32'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8", 32'(out_valid), 0);
    check(in_ready === 1'b1, "R8", 32'(in_ready), 1);

    // all-zero tuple: index 0 (R3)
    send_check(3'd0, "R3");
    @(negedge clk);
    check(out_valid === 1'b0, "R7", 32'(out_valid), 0);

    // R1 directed IPv4
    v4_ports = 32'h0050_1f90; v4_dst = 32'hc0a8_0101; v4_src = 32'h0a00_0002;
    send_check(3'd0, "R1");
    send_check(3'd1, "R1");

    // R2 cancelling IPv6 addresses
    randomize_tuple(); v6_dst = v6_src;
    send_check(3'd3, "R2");
    send_check(3'd4, "R2");

    // R4 unsupported kinds
    randomize_tuple();
    send_check(3'd2, "R4");
    send_check(3'd5, "R4");
    send_check(3'd6, "R4");
    send_check(3'd7, "R4");

    // random coverage
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      randomize_tuple();
      k = 3'($urandom_range(0, 7));
      send_check(k, (k == 3 || k == 4) ? "R2" : ((k == 0 || k == 1) ? "R1" : "R4"));
    end

    // R6/R7 stall then same-edge drain and refill
    @(negedge clk);
    randomize_tuple(); in_kind = 3'd4; in_valid = 1; out_ready = 0;
    e1 = model(3'd4);
    @(negedge clk);
    randomize_tuple(); in_kind = 3'd0;
    e2 = model(3'd0);
    check(in_ready === 1'b0, "R6", 32'(in_ready), 0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_index === e1[IW-1:0], "R6", 32'(out_index), 32'(e1[IW-1:0]));
      check(in_ready === 1'b0, "R6", 32'(in_ready), 0);
    end
    out_ready = 1;
    #1;
    check(in_ready === 1'b1, "R7", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 0;
    check(out_valid === 1'b1 && out_index === e2[IW-1:0] && out_unsup === e2[IW], "R7",
          32'(out_index), 32'(e2[IW-1:0]));
    @(negedge clk);
    check(out_valid === 1'b0, "R7", 32'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule